// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue with Redirect Flush

This block sits in the bus interface of a multicycle processor whose instructions vary in length. It fetches aligned memory words ahead of execution and keeps their bytes in a circular byte queue. A private fetch pointer, the scan address, runs ahead of the architectural program counter and paces the fetches. The decoder sees the oldest bytes of the queue. It states how many bytes the current instruction needs, and when it takes them the program counter advances by that amount.

When execution signals a taken branch, every queued byte is dropped. The program counter becomes the branch target and the scan address restarts at the word that holds the target. Each request carries an epoch tag that changes on every redirect. Responses that come back with an old tag are thrown away, so bytes fetched past the branch never reach the decoder. The target bytes arrive only after a fresh round trip to memory, which is the cost of a taken branch.

Top module: `prefetch_queue`

## Requirements
- R1: After reset, next_pc equals RESET_PC (default 16'h0100), the queue is empty so dec_ready is low for dec_len=1, and a request is offered at the aligned reset address with epoch tag 0.
- R2: Each accepted request (mem_req_valid and mem_req_ready both high at a clock edge) uses a WORD_BYTES-aligned address. Consecutive accepted requests within one epoch step by WORD_BYTES, and each request carries the current epoch.
- R3: A request is offered only while the queue's free bytes, less WORD_BYTES for every request still in flight, leave room for one more word. With DEPTH_BYTES=16 and WORD_BYTES=4 and no consumption, requests stop once four words are held or reserved. They resume in the cycle after a take frees a word.
- R4: Response bytes are stored in address order. Byte i of mem_rsp_data (bits 8i+7:8i) is the byte at the aligned address plus i. For the first response after a redirect, the bytes below the target's offset within its word are skipped.
- R5: dec_ready is high exactly when the queue holds at least dec_len bytes. Byte k of dec_bytes (bits 8k+7:8k) is the k-th oldest byte held, which is the byte at address next_pc+k.
- R6: A take (dec_take high while dec_ready is high at an edge) removes dec_len bytes and adds dec_len to next_pc. A take request while dec_ready is low changes neither.
- R7: A taken branch (br_taken high at an edge) empties the queue, loads br_target into next_pc, restarts fetching at the aligned target word and increments the epoch tag modulo 2^EPOCH_W.
- R8: A response whose mem_rsp_epoch differs from the current epoch is discarded and adds no bytes to the queue.
- R9: When a taken branch coincides with a decoder take and a current-epoch response at the same edge, the branch wins. next_pc becomes br_target and the queue is left empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_req_valid | output | 1 | Word fetch request offered |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | AW | Aligned fetch address |
| mem_req_epoch | output | EPOCH_W | Epoch tag sent with the request |
| mem_rsp_valid | input | 1 | Fetched word returned |
| mem_rsp_epoch | input | EPOCH_W | Epoch tag echoed by memory |
| mem_rsp_data | input | 8*WORD_BYTES | Returned word, byte 0 in low bits |
| dec_len | input | $clog2(MAX_TAKE+1) | Byte count the decoder needs |
| dec_take | input | 1 | Decoder consumes dec_len bytes |
| dec_ready | output | 1 | At least dec_len bytes are held |
| dec_bytes | output | 8*MAX_TAKE | Oldest queued bytes, oldest in low bits |
| next_pc | output | AW | Address of the oldest unconsumed byte |
| br_taken | input | 1 | Taken-branch redirect |
| br_target | input | AW | Redirect address |

## Verification
The case that needs the most care is a redirect that lands in the same cycle as a current-epoch response and a decoder take. The bench waits until the memory model is presenting a response with the live tag while the decoder is ready. It then raises br_taken and dec_take together. Afterwards next_pc must equal the target exactly, with no added take length, and the queue must be empty, so the coinciding response was dropped. A second overlap keeps responses held back across two redirects, then releases stale and fresh words back to back. dec_ready must stay low until the first fresh word lands, and the decoder must see the second target's bytes.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
    typedef logic [7:0] byte_t;

    function automatic byte_t word_byte(input logic [63:0] word, input int idx);
        return word[idx*8 +: 8];
    endfunction
endpackage

// File: rtl/pfq_byte_queue.sv
module pfq_byte_queue #(
    parameter int DEPTH = 16,
    parameter int WB    = 4,
    parameter int TAKE  = 4,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1),
    localparam int SW = $clog2(WB),
    localparam int LW = $clog2(TAKE + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wr_en,
    input  logic [WB*8-1:0]   wr_word,
    input  logic [SW-1:0]     wr_skip,
    input  logic              rd_take,
    input  logic [LW-1:0]     rd_len,
    output logic              rd_ready,
    output logic [TAKE*8-1:0] rd_bytes,
    output logic [CW-1:0]     used
);
    import pfq_pkg::*;

    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [PW-1:0]         rd;
        logic [PW-1:0]         wr;
        logic [CW-1:0]         used;
    } q_state_t;

    q_state_t s_d, s_q;
    logic [CW-1:0] wr_n, take_n;
    logic [PW-1:0] widx;

    assign rd_ready = s_q.used >= CW'(rd_len);
    assign used     = s_q.used;

    always_comb begin
        s_d    = s_q;
        widx   = '0;
        wr_n   = wr_en ? (CW'(WB) - CW'(wr_skip)) : '0;
        take_n = (rd_take && rd_ready) ? CW'(rd_len) : '0;
        for (int i = 0; i < WB; i++) begin
            widx = s_q.wr + PW'(i) - PW'(wr_skip);
            if (wr_en && (i >= int'(wr_skip)))
                s_d.mem[widx] = word_byte(64'(wr_word), i);
        end
        s_d.rd   = s_q.rd + PW'(take_n);
        s_d.wr   = s_q.wr + PW'(wr_n);
        s_d.used = s_q.used + wr_n - take_n;
        if (flush) begin
            s_d.rd   = '0;
            s_d.wr   = '0;
            s_d.used = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    for (genvar k = 0; k < TAKE; k++) begin : g_rd
        assign rd_bytes[k*8 +: 8] = s_q.mem[PW'(s_q.rd + PW'(k))];
    end

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.used <= CW'(DEPTH));
    a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (used == '0));
    a_r6_blocked_take: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_ready && !wr_en && !flush) |=> (used == $past(used)));
endmodule

// File: rtl/pfq_fetch_ctrl.sv
module pfq_fetch_ctrl #(
    parameter int AW    = 16,
    parameter int DEPTH = 16,
    parameter int WB    = 4,
    parameter int EW    = 2,
    parameter logic [AW-1:0] RESET_PC = 16'h0100,
    localparam int SW   = $clog2(WB),
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int MAXW = DEPTH / WB,
    localparam int FW   = $clog2(MAXW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic [AW-1:0] flush_addr,
    input  logic [CW-1:0] used,
    output logic          req_valid,
    input  logic          req_ready,
    output logic [AW-1:0] req_addr,
    output logic [EW-1:0] req_epoch,
    input  logic          rsp_valid,
    input  logic [EW-1:0] rsp_epoch,
    output logic          rsp_accept,
    output logic [SW-1:0] rsp_skip
);
    localparam logic [AW-1:0] RST_SCAN = RESET_PC & ~AW'(WB - 1);

    typedef struct packed {
        logic [AW-1:0] scan;
        logic [EW-1:0] epoch;
        logic [FW-1:0] infl;
        logic [SW-1:0] skip;
    } f_state_t;

    f_state_t s_d, s_q;
    logic [31:0] need;
    logic        fire;

    always_comb begin
        s_d        = s_q;
        need       = 32'(used) + (32'(s_q.infl) + 32'd1) * 32'(WB);
        req_valid  = (need <= 32'(DEPTH)) && !flush;
        req_addr   = s_q.scan;
        req_epoch  = s_q.epoch;
        fire       = req_valid && req_ready;
        rsp_accept = rsp_valid && (rsp_epoch == s_q.epoch) && !flush;
        rsp_skip   = s_q.skip;
        if (fire) s_d.scan = s_q.scan + AW'(WB);
        s_d.infl = s_q.infl + FW'(fire) - FW'(rsp_accept);
        if (rsp_accept) s_d.skip = '0;
        if (flush) begin
            s_d.scan  = {flush_addr[AW-1:SW], {SW{1'b0}}};
            s_d.skip  = flush_addr[SW-1:0];
            s_d.epoch = s_q.epoch + EW'(1);
            s_d.infl  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.scan  <= RST_SCAN;
            s_q.epoch <= '0;
            s_q.infl  <= '0;
            s_q.skip  <= RESET_PC[SW-1:0];
        end else begin
            s_q <= s_d;
        end
    end

    a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_addr[SW-1:0] == '0));
    a_r2_sequential: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !flush) |=> (req_addr == $past(req_addr) + AW'(WB)));
    a_r3_reserve_bound: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.infl <= FW'(MAXW));
    a_r7_epoch_step: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (req_epoch == $past(req_epoch) + EW'(1)));
    a_r8_stale_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_epoch != req_epoch)) |-> !rsp_accept);
endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue #(
    parameter int AW          = 16,
    parameter int WORD_BYTES  = 4,
    parameter int DEPTH_BYTES = 16,
    parameter int MAX_TAKE    = 4,
    parameter int EPOCH_W     = 2,
    parameter logic [AW-1:0] RESET_PC = 16'h0100,
    localparam int LW = $clog2(MAX_TAKE + 1),
    localparam int CW = $clog2(DEPTH_BYTES + 1),
    localparam int SW = $clog2(WORD_BYTES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    output logic                    mem_req_valid,
    input  logic                    mem_req_ready,
    output logic [AW-1:0]           mem_req_addr,
    output logic [EPOCH_W-1:0]      mem_req_epoch,
    input  logic                    mem_rsp_valid,
    input  logic [EPOCH_W-1:0]      mem_rsp_epoch,
    input  logic [WORD_BYTES*8-1:0] mem_rsp_data,
    input  logic [LW-1:0]           dec_len,
    input  logic                    dec_take,
    output logic                    dec_ready,
    output logic [MAX_TAKE*8-1:0]   dec_bytes,
    output logic [AW-1:0]           next_pc,
    input  logic                    br_taken,
    input  logic [AW-1:0]           br_target
);
    typedef struct packed {
        logic [AW-1:0] pc;
    } pc_state_t;

    pc_state_t     s_d, s_q;
    logic [CW-1:0] used;
    logic          rsp_accept;
    logic [SW-1:0] rsp_skip;

    pfq_fetch_ctrl #(
        .AW(AW), .DEPTH(DEPTH_BYTES), .WB(WORD_BYTES), .EW(EPOCH_W), .RESET_PC(RESET_PC)
    ) u_fetch (
        .clk(clk), .rst_n(rst_n), .flush(br_taken), .flush_addr(br_target), .used(used),
        .req_valid(mem_req_valid), .req_ready(mem_req_ready), .req_addr(mem_req_addr),
        .req_epoch(mem_req_epoch), .rsp_valid(mem_rsp_valid), .rsp_epoch(mem_rsp_epoch),
        .rsp_accept(rsp_accept), .rsp_skip(rsp_skip)
    );

    pfq_byte_queue #(
        .DEPTH(DEPTH_BYTES), .WB(WORD_BYTES), .TAKE(MAX_TAKE)
    ) u_queue (
        .clk(clk), .rst_n(rst_n), .flush(br_taken), .wr_en(rsp_accept),
        .wr_word(mem_rsp_data), .wr_skip(rsp_skip), .rd_take(dec_take && !br_taken),
        .rd_len(dec_len), .rd_ready(dec_ready), .rd_bytes(dec_bytes), .used(used)
    );

    always_comb begin
        s_d = s_q;
        if (br_taken)                  s_d.pc = br_target;
        else if (dec_take && dec_ready) s_d.pc = s_q.pc + AW'(dec_len);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q.pc <= RESET_PC;
        else        s_q    <= s_d;
    end

    assign next_pc = s_q.pc;

    a_r6_pc_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_take && dec_ready && !br_taken) |=> (next_pc == $past(next_pc) + AW'($past(dec_len))));
    a_r6_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec_ready && !br_taken) |=> (next_pc == $past(next_pc)));
    a_r9_branch_wins: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |=> (next_pc == $past(br_target)));
endmodule

// File: tb/prefetch_queue_bench.sv
module prefetch_queue_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [15:0] mem_req_addr;
    logic [1:0]  mem_req_epoch;
    logic        mem_rsp_valid;
    logic [1:0]  mem_rsp_epoch;
    logic [31:0] mem_rsp_data;
    logic [2:0]  dec_len = 3'd1;
    logic        dec_take = 1'b0;
    logic        dec_ready;
    logic [31:0] dec_bytes;
    logic [15:0] next_pc;
    logic        br_taken = 1'b0;
    logic [15:0] br_target = '0;

    int n_cmp = 0;
    int n_bad = 0;
    logic [15:0] exp_pc = 16'h0100;
    logic [15:0] exp_scan = 16'h0100;
    logic [1:0]  exp_ep = 2'd0;

    logic [15:0] pa [0:31];
    logic [1:0]  pe [0:31];
    int ph = 0, pt = 0, cyc = 0;
    bit hold = 0, throttle = 0;

    always #4 clk = ~clk;

    prefetch_queue u_prefetch_queue (
        .clk(clk), .rst_n(rst_n), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_req_epoch(mem_req_epoch), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_epoch(mem_rsp_epoch), .mem_rsp_data(mem_rsp_data), .dec_len(dec_len),
        .dec_take(dec_take), .dec_ready(dec_ready), .dec_bytes(dec_bytes), .next_pc(next_pc),
        .br_taken(br_taken), .br_target(br_target)
    );

    function automatic logic [7:0] mbyte(input logic [15:0] a);
        logic [15:0] t;
        t = a * 16'd7 + (a >> 8) + 16'd3;
        return t[7:0];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // memory model: in-order responses, at least one cycle of latency
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            ph <= 0; pt <= 0; mem_rsp_valid <= 1'b0; mem_req_ready <= 1'b1;
            mem_rsp_epoch <= '0; mem_rsp_data <= '0;
        end else begin
            if (mem_req_valid && mem_req_ready) begin
                pa[pt % 32] <= mem_req_addr;
                pe[pt % 32] <= mem_req_epoch;
                pt <= pt + 1;
            end
            mem_req_ready <= !(throttle && (cyc % 3 == 0));
            if (!hold && ph != pt) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_epoch <= pe[ph % 32];
                for (int i = 0; i < 4; i++) mem_rsp_data[i*8 +: 8] <= mbyte(pa[ph % 32] + 16'(i));
                ph <= ph + 1;
            end else begin
                mem_rsp_valid <= 1'b0;
            end
        end
    end

    // R2 request monitor
    always @(negedge clk) begin
        #2;
        if (rst_n && mem_req_valid && mem_req_ready) begin
            chk("R2 req addr", 32'(mem_req_addr), 32'(exp_scan));
            chk("R2 req epoch", 32'(mem_req_epoch), 32'(exp_ep));
            exp_scan = exp_scan + 16'd4;
        end
    end

    task automatic take(input int len);
        int w;
        dec_len = 3'(len);
        #1;
        w = 0;
        while (!dec_ready && w < 300) begin @(negedge clk); #1; w++; end
        chk("R5 ready", 32'(dec_ready), 32'd1);
        for (int k = 0; k < len; k++)
            chk("R4/R5 byte", 32'(dec_bytes[k*8 +: 8]), 32'(mbyte(exp_pc + 16'(k))));
        chk("R6 pc before", 32'(next_pc), 32'(exp_pc));
        dec_take = 1'b1;
        @(posedge clk);
        @(negedge clk);
        dec_take = 1'b0;
        exp_pc = exp_pc + 16'(len);
        #1;
        chk("R6 pc after", 32'(next_pc), 32'(exp_pc));
    endtask

    task automatic branch(input logic [15:0] tgt);
        br_taken = 1'b1;
        br_target = tgt;
        @(posedge clk);
        @(negedge clk);
        br_taken = 1'b0;
        dec_take = 1'b0;
        exp_pc = tgt;
        exp_scan = {tgt[15:2], 2'b00};
        exp_ep = exp_ep + 2'd1;
        dec_len = 3'd1;
        #1;
        chk("R7 pc", 32'(next_pc), 32'(tgt));
        chk("R7 empty", 32'(dec_ready), 32'd0);
        chk("R7 epoch", 32'(mem_req_epoch), 32'(exp_ep));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int w;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 pc", 32'(next_pc), 32'h0100);
        chk("R1 empty", 32'(dec_ready), 32'd0);
        chk("R1 req valid", 32'(mem_req_valid), 32'd1);
        chk("R1 req addr", 32'(mem_req_addr), 32'h0100);
        chk("R1 epoch", 32'(mem_req_epoch), 32'd0);

        // R4 R5 R6: length sweep from reset
        for (int r = 0; r < 3; r++)
            for (int l = 1; l <= 4; l++) take(l);

        // R2: throttled memory ready
        throttle = 1;
        for (int i = 0; i < 16; i++) take((i * 3) % 4 + 1);
        throttle = 0;

        // R4: unaligned redirect drops leading bytes
        branch(16'h0403);
        for (int l = 1; l <= 4; l++) take(l);
        for (int l = 4; l >= 1; l--) take(l);

        // R3: fill without consuming, then free one word
        branch(16'h0500);
        repeat (40) @(negedge clk);
        #1;
        chk("R3 full stops requests", 32'(mem_req_valid), 32'd0);
        take(4);
        chk("R3 resume after take", 32'(mem_req_valid), 32'd1);
        take(4);
        take(2);

        // R6: take while not ready is ignored
        hold = 1;
        branch(16'h0600);
        dec_len = 3'd4;
        dec_take = 1'b1;
        @(posedge clk);
        @(negedge clk);
        dec_take = 1'b0;
        #1;
        chk("R6 blocked take pc", 32'(next_pc), 32'h0600);

        // R8: stale responses released after a second redirect
        repeat (6) @(negedge clk);
        branch(16'h0713);
        repeat (6) @(negedge clk);
        hold = 0;
        #1;
        dec_len = 3'd1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            #1;
            chk("R8 stale ignored", 32'(dec_ready), 32'd0);
        end
        for (int l = 1; l <= 4; l++) take(l);

        // R9: redirect, take and live response in one cycle
        for (int rep = 0; rep < 3; rep++) begin
            dec_len = 3'd1;
            #1;
            w = 0;
            while (!(mem_rsp_valid && mem_rsp_epoch == exp_ep && dec_ready) && w < 300) begin
                @(negedge clk); #1; w++;
            end
            chk("R9 setup", 32'(mem_rsp_valid && dec_ready), 32'd1);
            dec_take = 1'b1;
            branch(16'h0800 + 16'(rep * 16'h31));
            chk("R9 pc exact", 32'(next_pc), 32'(16'h0800 + 16'(rep * 16'h31)));
            for (int l = 1; l <= 3; l++) take(l);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule